// File: doc/BRIEF.md
# Vector String Isolate Unit

The unit takes a 128-bit vector that holds a zero-terminated string and returns only the string. It splits the word into elements of 8 or 16 bits. It scans them from the most significant end or from the least significant end and stops at the first element that is all zero. Every element from the scan start up to and including that terminator is kept, and every element beyond it is cleared. A vector with no zero element passes through unchanged.

A 2-bit selector sets the element size and the scan direction. An optional record flag asks for a 4-bit condition value, which reports whether a terminator was found, together with a write enable for the condition field it belongs to. The masking logic is purely combinational. Its result, the condition value and a valid strobe are captured on the clock edge after an input is presented.

Top module: `vsi_top`

## Requirements
- R1: `in_sel` encoding: 0 = byte elements scanned from the left, 1 = bytes from the right, 2 = halfwords from the left, 3 = halfwords from the right. "Left" is the most significant end, so in byte mode element 0 occupies bits 127:120.
- R2: In left mode, let N be the 1-based position of the first zero element counted from the left. The N leftmost elements are kept and all other bits are zero.
- R3: In right mode, N is counted from the right. The N rightmost elements are kept and all other bits are zero.
- R4: Halfword mode treats the vector as 8 elements of 16 bits. Only a whole zero halfword terminates the scan; a zero byte inside a nonzero halfword does not.
- R5: When no element equals zero, `out_vec` equals the input vector in every mode.
- R6: With `in_rec` set, `out_cond_we` is 1 and `out_cond` is 4'b0010 when a zero element was found, or 4'b0000 when none was found. Bits 3, 1 weight 2... specifically: only the bit of weight 2 can ever be set.
- R7: With `in_rec` clear, `out_cond_we` is 0 and `out_cond` is 4'b0000.
- R8: The outputs update on the rising edge after a cycle with `in_valid` high, and `out_valid` is high for exactly that cycle. On cycles without `in_valid`, `out_valid` is low.
- R9: While `rst_n` is low, `out_valid`, `out_cond_we`, `out_cond` and `out_vec` are zero.
- R10: `out_cond_fld` always reads 6, the index of the condition field the value targets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operands present this cycle |
| in_vec | input | 128 | Source vector |
| in_sel | input | 2 | Element size (bit 1) and scan direction (bit 0) |
| in_rec | input | 1 | Produce a condition value |
| out_valid | output | 1 | Registered result valid |
| out_vec | output | 128 | Isolated string |
| out_cond | output | 4 | Condition value |
| out_cond_we | output | 1 | Condition field write enable |
| out_cond_fld | output | 3 | Target condition field index |

## Verification
The hardest case to reach is a halfword scan over a vector whose zero bytes lie inside nonzero halfwords. In that case the byte and halfword interpretations give different terminators. The stimulus therefore uses vectors with misaligned zero bytes ahead of an aligned zero halfword. It applies the same vector in both element sizes and both directions, and it places the terminator in the first and in the last scanned element, so that the boundary counts of 1 and of the element total are both covered.

// File: rtl/vsi_pkg.sv
package vsi_pkg;
  localparam int VSI_VEC_W    = 128;
  localparam int VSI_CC_W     = 4;
  localparam int VSI_CC_FOUND = 1;   // bit of weight 2
  localparam int VSI_CC_FLD   = 6;
  localparam int VSI_FLD_W    = 3;

  typedef enum logic [1:0] {
    SEL_BYTE_L = 2'd0,
    SEL_BYTE_R = 2'd1,
    SEL_HALF_L = 2'd2,
    SEL_HALF_R = 2'd3
  } vsi_sel_e;

  typedef struct packed {
    logic                 found;
    logic [VSI_VEC_W-1:0] data;
  } vsi_lane_t;
endpackage

// File: rtl/vsi_zero_scan.sv
module vsi_zero_scan #(
  parameter int VEC_W  = 128,
  parameter int ELEM_W = 8,
  localparam int NUM   = VEC_W / ELEM_W,
  localparam int CNT_W = $clog2(NUM + 1)
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic             from_right_i,
  output logic             found_o,
  output logic [CNT_W-1:0] count_o
);
  logic [NUM-1:0] is_zero;   // index 0 = leftmost element

  for (genvar g = 0; g < NUM; g++) begin : g_cmp
    assign is_zero[g] = (vec_i[VEC_W-1-g*ELEM_W -: ELEM_W] == '0);
  end

  always_comb begin
    found_o = 1'b0;
    count_o = '0;
    for (int i = 0; i < NUM; i++) begin
      int idx;
      idx = from_right_i ? (NUM - 1 - i) : i;
      if (!found_o && is_zero[idx]) begin
        found_o = 1'b1;
        count_o = CNT_W'(i + 1);
      end
    end
  end
endmodule

// File: rtl/vsi_keep_mask.sv
module vsi_keep_mask #(
  parameter int VEC_W  = 128,
  parameter int ELEM_W = 8,
  localparam int NUM   = VEC_W / ELEM_W,
  localparam int CNT_W = $clog2(NUM + 1)
) (
  input  logic             found_i,
  input  logic             from_right_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [VEC_W-1:0] mask_o
);
  logic [CNT_W:0] cnt_ext;
  assign cnt_ext = {1'b0, count_i};

  for (genvar g = 0; g < NUM; g++) begin : g_elem
    localparam logic [CNT_W:0] LPOS = (CNT_W+1)'(g);
    localparam logic [CNT_W:0] RPOS = (CNT_W+1)'(NUM - 1 - g);
    logic keep;
    assign keep = !found_i || (from_right_i ? (RPOS < cnt_ext) : (LPOS < cnt_ext));
    assign mask_o[VEC_W-1-g*ELEM_W -: ELEM_W] = {ELEM_W{keep}};
  end
endmodule

// File: rtl/vsi_lane.sv
module vsi_lane
  import vsi_pkg::*;
#(
  parameter int VEC_W  = VSI_VEC_W,
  parameter int ELEM_W = 8,
  localparam int NUM   = VEC_W / ELEM_W,
  localparam int CNT_W = $clog2(NUM + 1)
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic             from_right_i,
  output logic             found_o,
  output logic [VEC_W-1:0] data_o
);
  logic [CNT_W-1:0] count;
  logic [VEC_W-1:0] mask;

  vsi_zero_scan #(.VEC_W(VEC_W), .ELEM_W(ELEM_W)) u_scan (
    .vec_i        (vec_i),
    .from_right_i (from_right_i),
    .found_o      (found_o),
    .count_o      (count)
  );

  vsi_keep_mask #(.VEC_W(VEC_W), .ELEM_W(ELEM_W)) u_mask (
    .found_i      (found_o),
    .from_right_i (from_right_i),
    .count_i      (count),
    .mask_o       (mask)
  );

  assign data_o = vec_i & mask;
endmodule

// File: rtl/vsi_top.sv
module vsi_top
  import vsi_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [VSI_VEC_W-1:0] in_vec,
  input  logic [1:0]           in_sel,
  input  logic                 in_rec,
  output logic                 out_valid,
  output logic [VSI_VEC_W-1:0] out_vec,
  output logic [VSI_CC_W-1:0]  out_cond,
  output logic                 out_cond_we,
  output logic [VSI_FLD_W-1:0] out_cond_fld
);
  localparam int NSIZE = 2;   // 0: 8-bit elements, 1: 16-bit elements

  vsi_lane_t lane [NSIZE];
  logic      from_right;
  logic      size_sel;

  assign from_right = in_sel[0];
  assign size_sel   = in_sel[1];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    vsi_lane #(.VEC_W(VSI_VEC_W), .ELEM_W(8 << s)) u_lane (
      .vec_i        (in_vec),
      .from_right_i (from_right),
      .found_o      (lane[s].found),
      .data_o       (lane[s].data)
    );
  end

  // next-state
  logic                 valid_d;
  logic [VSI_VEC_W-1:0] vec_d;
  logic [VSI_CC_W-1:0]  cond_d;
  logic                 we_d;
  logic                 load_en;

  always_comb begin
    vsi_lane_t pick;
    pick    = size_sel ? lane[1] : lane[0];
    load_en = in_valid;
    valid_d = in_valid;
    vec_d   = pick.data;
    we_d    = in_rec;
    cond_d  = '0;
    if (in_rec) cond_d[VSI_CC_FOUND] = pick.found;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vec     <= '0;
      out_cond    <= '0;
      out_cond_we <= 1'b0;
    end else if (load_en) begin
      out_vec     <= vec_d;
      out_cond    <= cond_d;
      out_cond_we <= we_d;
    end
  end

  assign out_cond_fld = VSI_FLD_W'(VSI_CC_FLD);
endmodule

// File: rtl/vsi_top_chk.sv
module vsi_top_chk
  import vsi_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic [VSI_VEC_W-1:0] in_vec,
  input logic                 in_rec,
  input logic                 out_valid,
  input logic [VSI_VEC_W-1:0] out_vec,
  input logic [VSI_CC_W-1:0]  out_cond,
  input logic                 out_cond_we,
  input logic [VSI_FLD_W-1:0] out_cond_fld
);
  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid));

  assert_no_new_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((out_vec & ~$past(in_vec)) == '0));

  assert_we_tracks_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_cond_we == $past(in_rec)));

  assert_cond_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_cond_we) |-> (out_cond == '0));

  assert_cond_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_cond) <= 1 && out_cond[3] == 1'b0
                   && out_cond[0] == 1'b0));

  assert_field_idx_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_cond_fld == 3'd6);
endmodule

bind vsi_top vsi_top_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_vec       (in_vec),
  .in_rec       (in_rec),
  .out_valid    (out_valid),
  .out_vec      (out_vec),
  .out_cond     (out_cond),
  .out_cond_we  (out_cond_we),
  .out_cond_fld (out_cond_fld)
);

// File: tb/sim_vsi_top.sv
`timescale 1ns/1ps
module sim_vsi_top;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic [127:0] in_vec;
  logic [1:0]   in_sel;
  logic         in_rec;
  logic         out_valid;
  logic [127:0] out_vec;
  logic [3:0]   out_cond;
  logic         out_cond_we;
  logic [2:0]   out_cond_fld;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  vsi_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .in_sel(in_sel), .in_rec(in_rec), .out_valid(out_valid), .out_vec(out_vec),
    .out_cond(out_cond), .out_cond_we(out_cond_we), .out_cond_fld(out_cond_fld)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference: element 0 is the most significant element
  function automatic logic [128:0] model(input logic [127:0] v, input logic [1:0] sel);
    int w = sel[1] ? 16 : 8;
    int n = 128 / w;
    int cnt = 0;
    logic fnd = 1'b0;
    logic [127:0] r = '0;
    for (int i = 0; i < n; i++) begin
      int e = sel[0] ? n - 1 - i : i;
      logic [15:0] el = '0;
      for (int b = 0; b < w; b++) el[b] = v[127 - e*w - (w-1) + b];
      if (!fnd && el == 16'h0) begin fnd = 1'b1; cnt = i + 1; end
    end
    for (int e = 0; e < n; e++) begin
      int pos = sel[0] ? n - 1 - e : e;
      if (!fnd || pos < cnt)
        for (int b = 0; b < w; b++) r[127 - e*w - b] = v[127 - e*w - b];
    end
    return {fnd, r};
  endfunction

  task automatic apply(input logic [127:0] v, input logic [1:0] sel, input logic rec,
                       input string req);
    logic [128:0] m;
    @(negedge clk);
    in_valid = 1'b1; in_vec = v; in_sel = sel; in_rec = rec;
    @(posedge clk); #1;
    in_valid = 1'b0;
    m = model(v, sel);
    chk(req, out_vec, m[127:0]);
    chk("R8 valid", {127'd0, out_valid}, 128'd1);
    chk(rec ? "R6 cond" : "R7 cond", {124'd0, out_cond}, rec ? {126'd0, m[128], 1'b0} : 128'd0);
    chk(rec ? "R6 we" : "R7 we", {127'd0, out_cond_we}, {127'd0, rec});
    chk("R10 field", {125'd0, out_cond_fld}, 128'd6);
  endtask

  task automatic t_reset;
    #1;
    chk("R9 valid", {127'd0, out_valid}, 128'd0);
    chk("R9 vec", out_vec, 128'd0);
    chk("R9 cond", {123'd0, out_cond_we, out_cond}, 128'd0);
  endtask

  task automatic t_byte_left;   // R1 R2
    apply(128'h41424300_45464748_494A4B4C_4D4E4F50, 2'd0, 1'b1, "R2 byte left");
    chk("R2 literal", out_vec, 128'h41424300_00000000_00000000_00000000);
  endtask

  task automatic t_byte_right;  // R1 R3
    apply(128'h11223344_55667788_99AABBCC_00EEFF01, 2'd1, 1'b1, "R3 byte right");
    chk("R3 literal", out_vec, 128'h00000000_00000000_00000000_00EEFF01);
  endtask

  task automatic t_half;        // R4
    logic [127:0] v = 128'h1200_0034_5600_0000_ABCD_0001_0100_FFFF;
    apply(v, 2'd2, 1'b1, "R4 half left");
    chk("R4 literal", out_vec, 128'h1200_0034_5600_0000_0000_0000_0000_0000);
    apply(v, 2'd0, 1'b1, "R1 byte on same vector");
    apply(128'h1111_0000_2222_3300_0044_5500_0066_7700, 2'd3, 1'b1, "R4 half right");
    chk("R4 right literal", out_vec, 128'h0000_0000_2222_3300_0044_5500_0066_7700);
  endtask

  task automatic t_no_zero;     // R5
    logic [127:0] v = 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10;
    for (int s = 0; s < 4; s++) begin
      apply(v, 2'(s), 1'b1, "R5 passthrough");
      chk("R5 literal", out_vec, v);
    end
  endtask

  task automatic t_edges;       // R2 R3 boundary counts
    apply(128'h00AABBCC_DDEEFF11_22334455_66778899, 2'd0, 1'b1, "R2 first elem");
    apply(128'h00AABBCC_DDEEFF11_22334455_66778899, 2'd1, 1'b1, "R3 last elem");
    apply(128'h0000AABB_CCDDEEFF_11223344_55667788, 2'd3, 1'b1, "R3 half last elem");
    apply(128'hAABB_CCDD_EEFF_1122_3344_5566_7788_0000, 2'd2, 1'b1, "R2 half last elem");
  endtask

  task automatic t_norec;       // R7
    apply(128'h41424300_45464748_494A4B4C_4D4E4F50, 2'd0, 1'b0, "R7 data");
    apply(128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10, 2'd2, 1'b0, "R7 data nofind");
  endtask

  task automatic t_idle;        // R8
    @(negedge clk);
    @(posedge clk); #1;
    chk("R8 idle valid", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_vec = '0; in_sel = '0; in_rec = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_byte_left();
    t_byte_right();
    t_half();
    t_no_zero();
    t_edges();
    t_norec();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule